// File: doc/BRIEF.md
# Single-Entry Tagged Translation Cache

This block keeps one cached virtual-to-physical page translation for a page-table walker. Each cached translation carries a 9-bit address-space tag, a global flag, a virtual page address, a physical page base, the 32-bit page-table entry, the physical address that entry was read from, and a one-bit level. Level 0 means a 4 KiB page. Level 1 means a 4 MiB superpage. The level sets how many low address bits pass through unchanged as the page offset.

A lookup is purely combinational. The caller presents an address-space tag and a virtual address. In the same cycle the block returns a hit flag, the translated physical address and the stored fields. All other operations are registered on the rising clock edge:

- A fill loads a new translation and overwrites whatever was held before.
- An update rewrites only the stored page-table entry, for example after accessed or dirty bits change.
- A flush invalidates the held translation when it matches the flush's optional address-space qualifier and optional address qualifier.

The control is a two-state machine. The states are `ST_EMPTY` (nothing cached) and `ST_VALID` (one translation held). The transitions are:

- `ST_EMPTY -> ST_VALID` on a fill.
- `ST_VALID -> ST_VALID` on a fill (replacement), on an update, or when nothing happens.
- `ST_VALID -> ST_EMPTY` on a matching flush with no fill in the same cycle.
- `ST_EMPTY -> ST_EMPTY` on anything except a fill. Flushes and updates here do nothing.

Top module: `xlat_tlb1`

## Requirements
- R1: After reset the entry is empty: `lk_hit` is 0 for every lookup until the first fill.
- R2: A fill (`fill_en`=1) stores the tag, global flag, virtual address, page-table entry, its address and level, replacing any held translation. A later hit returns `lk_pte`, `lk_pte_addr`, `lk_level` and `lk_global` exactly as filled.
- R3: On a hit, `lk_paddr` equals the filled physical address with its offset bits cleared, OR-ed with the lookup virtual address masked to the offset bits.
- R4: The offset mask covers the low 12 bits when the stored level is 0 and the low 22 bits when it is 1. The page compare ignores those bits.
- R5: A lookup hits only when the held entry is valid, the page bits match, and either `lk_asid` equals the stored tag or the stored global flag is 1.
- R6: An update (`upd_en`=1) on a valid entry replaces only the stored page-table entry; the physical address, tag and address of the entry stay unchanged. An update on an empty entry has no effect.
- R7: A flush with neither qualifier (`flush_use_asid`=0, `flush_use_addr`=0) invalidates a valid entry. A flush on an empty entry leaves it empty and later fills work normally.
- R8: A flush with `flush_use_asid`=1 matches only a non-global entry whose tag equals `flush_asid`. Global entries survive it.
- R9: A flush with `flush_use_addr`=1 matches only when `flush_vaddr` lies in the held page under the held level's mask. When both qualifiers are set, both must match.
- R10: In one cycle, a fill takes precedence over a flush and an update, and a matching flush takes precedence over an update.
- R11: On a miss, `lk_paddr`, `lk_pte`, `lk_pte_addr`, `lk_level` and `lk_global` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_asid | input | 9 | Lookup address-space tag |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched the held translation |
| lk_paddr | output | 34 | Translated physical address |
| lk_pte | output | 32 | Stored page-table entry |
| lk_pte_addr | output | 34 | Physical address of the stored entry |
| lk_level | output | 1 | Stored level (0 page, 1 superpage) |
| lk_global | output | 1 | Stored global flag |
| fill_en | input | 1 | Load a new translation |
| fill_asid | input | 9 | Tag to store |
| fill_global | input | 1 | Global flag to store |
| fill_vaddr | input | 32 | Virtual address to store |
| fill_paddr | input | 34 | Physical address; offset bits are dropped |
| fill_pte | input | 32 | Page-table entry to store |
| fill_pte_addr | input | 34 | Address of that entry |
| fill_level | input | 1 | Level to store |
| upd_en | input | 1 | Rewrite the stored page-table entry |
| upd_pte | input | 32 | New page-table entry value |
| flush_en | input | 1 | Flush request |
| flush_use_asid | input | 1 | Qualify the flush by tag |
| flush_asid | input | 9 | Tag qualifier |
| flush_use_addr | input | 1 | Qualify the flush by address |
| flush_vaddr | input | 32 | Address qualifier |

## Verification
The assertions assume that every control and data input carries a known value whenever reset is released. They also assume that the flush qualifier inputs only matter while `flush_en` is high. The bench drives all inputs at the falling clock edge, holds each enable high for exactly one rising edge, and returns every enable to 0 between operations. It never drives a level outside 0 and 1. Lookups are presented in the half cycle after the registering edge and sampled 1 ns later, so each check sees one stable entry.

// File: rtl/xlat_tlb1_pkg.sv
package xlat_tlb1_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_VALID = 1'b1
    } tlb1_state_e;
endpackage

// File: rtl/xlat_tlb1_mask.sv
module xlat_tlb1_mask #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int LVL_BITS  = 10,
    parameter int LEVEL_W   = 1
) (
    input  logic [LEVEL_W-1:0] level,
    output logic [VA_W-1:0]    mask
);
    always_comb begin
        int unsigned span;
        span = PAGE_BITS + LVL_BITS * int'(level);
        for (int i = 0; i < VA_W; i++) begin
            mask[i] = (i < int'(span));
        end
    end
endmodule

// File: rtl/xlat_tlb1_match.sv
module xlat_tlb1_match #(
    parameter int VA_W   = 32,
    parameter int ASID_W = 9
) (
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VA_W-1:0]   ent_vaddr,
    input  logic [VA_W-1:0]   ent_mask,
    input  logic [ASID_W-1:0] q_asid,
    input  logic [VA_W-1:0]   q_vaddr,
    output logic              asid_eq,
    output logic              tag_eq
);
    // page compare ignores the offset bits of the held level
    assign asid_eq = (ent_asid == q_asid);
    assign tag_eq  = (((ent_vaddr ^ q_vaddr) & ~ent_mask) == '0);
endmodule

// File: rtl/xlat_tlb1_store.sv
module xlat_tlb1_store
    import xlat_tlb1_pkg::*;
#(
    parameter int ASID_W  = 9,
    parameter int VA_W    = 32,
    parameter int PA_W    = 34,
    parameter int PTE_W   = 32,
    parameter int LEVEL_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic               fill_global,
    input  logic [VA_W-1:0]    fill_vaddr,
    input  logic [PA_W-1:0]    fill_base,
    input  logic [PTE_W-1:0]   fill_pte,
    input  logic [PA_W-1:0]    fill_pte_addr,
    input  logic [LEVEL_W-1:0] fill_level,
    input  logic               upd_en,
    input  logic [PTE_W-1:0]   upd_pte,
    input  logic               flush_hit,
    output logic               ent_valid,
    output logic [ASID_W-1:0]  ent_asid,
    output logic               ent_global,
    output logic [VA_W-1:0]    ent_vaddr,
    output logic [PA_W-1:0]    ent_base,
    output logic [PTE_W-1:0]   ent_pte,
    output logic [PA_W-1:0]    ent_pte_addr,
    output logic [LEVEL_W-1:0] ent_level
);
    tlb1_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (fill_en) state_d = ST_VALID;
            ST_VALID: begin
                if (fill_en)        state_d = ST_VALID;
                else if (flush_hit) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_asid     <= '0;
            ent_global   <= 1'b0;
            ent_vaddr    <= '0;
            ent_base     <= '0;
            ent_pte      <= '0;
            ent_pte_addr <= '0;
            ent_level    <= '0;
        end else if (fill_en) begin
            ent_asid     <= fill_asid;
            ent_global   <= fill_global;
            ent_vaddr    <= fill_vaddr;
            ent_base     <= fill_base;
            ent_pte      <= fill_pte;
            ent_pte_addr <= fill_pte_addr;
            ent_level    <= fill_level;
        end else if (upd_en && state_q == ST_VALID && !flush_hit) begin
            ent_pte <= upd_pte;
        end
    end

    assign ent_valid = (state_q == ST_VALID);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state_q == ST_EMPTY);

    // R2
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> state_q == ST_VALID);

    // R10
    fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ent_pte == $past(fill_pte));

    // R6
    upd_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(ent_base) && $stable(ent_asid) && $stable(ent_vaddr)
                     && $stable(ent_pte_addr) && $stable(ent_level));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_hit && !fill_en) |=> state_q == ST_EMPTY);
endmodule

// File: rtl/xlat_tlb1.sv
module xlat_tlb1 #(
    parameter int ASID_W    = 9,
    parameter int VA_W      = 32,
    parameter int PA_W      = 34,
    parameter int PTE_W     = 32,
    parameter int LEVEL_W   = 1,
    parameter int PAGE_BITS = 12,
    parameter int LVL_BITS  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               lk_hit,
    output logic [PA_W-1:0]    lk_paddr,
    output logic [PTE_W-1:0]   lk_pte,
    output logic [PA_W-1:0]    lk_pte_addr,
    output logic [LEVEL_W-1:0] lk_level,
    output logic               lk_global,
    input  logic               fill_en,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic               fill_global,
    input  logic [VA_W-1:0]    fill_vaddr,
    input  logic [PA_W-1:0]    fill_paddr,
    input  logic [PTE_W-1:0]   fill_pte,
    input  logic [PA_W-1:0]    fill_pte_addr,
    input  logic [LEVEL_W-1:0] fill_level,
    input  logic               upd_en,
    input  logic [PTE_W-1:0]   upd_pte,
    input  logic               flush_en,
    input  logic               flush_use_asid,
    input  logic [ASID_W-1:0]  flush_asid,
    input  logic               flush_use_addr,
    input  logic [VA_W-1:0]    flush_vaddr
);
    logic               ent_valid, ent_global;
    logic [ASID_W-1:0]  ent_asid;
    logic [VA_W-1:0]    ent_vaddr, ent_mask, fill_mask;
    logic [PA_W-1:0]    ent_base, ent_pte_addr, fill_base;
    logic [PTE_W-1:0]   ent_pte;
    logic [LEVEL_W-1:0] ent_level;
    logic               lk_asid_eq, lk_tag_eq, fl_asid_eq, fl_tag_eq, flush_hit;

    xlat_tlb1_mask #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .LVL_BITS(LVL_BITS), .LEVEL_W(LEVEL_W))
        u_fill_mask (.level(fill_level), .mask(fill_mask));
    xlat_tlb1_mask #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .LVL_BITS(LVL_BITS), .LEVEL_W(LEVEL_W))
        u_ent_mask (.level(ent_level), .mask(ent_mask));

    assign fill_base = fill_paddr & ~PA_W'(fill_mask);

    xlat_tlb1_match #(.VA_W(VA_W), .ASID_W(ASID_W)) u_lk_match (
        .ent_asid(ent_asid), .ent_vaddr(ent_vaddr), .ent_mask(ent_mask),
        .q_asid(lk_asid), .q_vaddr(lk_vaddr),
        .asid_eq(lk_asid_eq), .tag_eq(lk_tag_eq));

    xlat_tlb1_match #(.VA_W(VA_W), .ASID_W(ASID_W)) u_fl_match (
        .ent_asid(ent_asid), .ent_vaddr(ent_vaddr), .ent_mask(ent_mask),
        .q_asid(flush_asid), .q_vaddr(flush_vaddr),
        .asid_eq(fl_asid_eq), .tag_eq(fl_tag_eq));

    assign flush_hit = flush_en && ent_valid
                     && (!flush_use_asid || (fl_asid_eq && !ent_global))
                     && (!flush_use_addr || fl_tag_eq);

    xlat_tlb1_store #(.ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .LEVEL_W(LEVEL_W))
        u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_asid(fill_asid), .fill_global(fill_global),
        .fill_vaddr(fill_vaddr), .fill_base(fill_base), .fill_pte(fill_pte),
        .fill_pte_addr(fill_pte_addr), .fill_level(fill_level),
        .upd_en(upd_en), .upd_pte(upd_pte), .flush_hit(flush_hit),
        .ent_valid(ent_valid), .ent_asid(ent_asid), .ent_global(ent_global),
        .ent_vaddr(ent_vaddr), .ent_base(ent_base), .ent_pte(ent_pte),
        .ent_pte_addr(ent_pte_addr), .ent_level(ent_level));

    always_comb begin
        lk_hit      = ent_valid && lk_tag_eq && (lk_asid_eq || ent_global);
        lk_paddr    = '0;
        lk_pte      = '0;
        lk_pte_addr = '0;
        lk_level    = '0;
        lk_global   = 1'b0;
        if (lk_hit) begin
            lk_paddr    = ent_base | PA_W'(lk_vaddr & ent_mask);
            lk_pte      = ent_pte;
            lk_pte_addr = ent_pte_addr;
            lk_level    = ent_level;
            lk_global   = ent_global;
        end
    end

    // R3
    hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

    // R8
    global_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && flush_use_asid && !flush_use_addr && ent_valid && ent_global && !fill_en)
        |=> ent_valid);
endmodule

// File: tb/xlat_tlb1_tb.sv
`timescale 1ns/1ps
module xlat_tlb1_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  lk_asid = '0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [33:0] lk_paddr, lk_pte_addr;
    logic [31:0] lk_pte;
    logic [0:0]  lk_level;
    logic        lk_global;
    logic        fill_en = 0, fill_global = 0;
    logic [8:0]  fill_asid = '0;
    logic [31:0] fill_vaddr = '0, fill_pte = '0;
    logic [33:0] fill_paddr = '0, fill_pte_addr = '0;
    logic [0:0]  fill_level = '0;
    logic        upd_en = 0;
    logic [31:0] upd_pte = '0;
    logic        flush_en = 0, flush_use_asid = 0, flush_use_addr = 0;
    logic [8:0]  flush_asid = '0;
    logic [31:0] flush_vaddr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xlat_tlb1 u_dut (
        .clk(clk), .rst_n(rst_n), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_pte(lk_pte), .lk_pte_addr(lk_pte_addr),
        .lk_level(lk_level), .lk_global(lk_global),
        .fill_en(fill_en), .fill_asid(fill_asid), .fill_global(fill_global),
        .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr), .fill_pte(fill_pte),
        .fill_pte_addr(fill_pte_addr), .fill_level(fill_level),
        .upd_en(upd_en), .upd_pte(upd_pte),
        .flush_en(flush_en), .flush_use_asid(flush_use_asid), .flush_asid(flush_asid),
        .flush_use_addr(flush_use_addr), .flush_vaddr(flush_vaddr));

    typedef struct packed {
        logic        fill;
        logic [8:0]  f_asid;
        logic        f_glob;
        logic [31:0] f_va;
        logic [33:0] f_pa;
        logic        f_lvl;
        logic [8:0]  l_asid;
        logic [31:0] l_va;
        logic        e_hit;
        logic [33:0] e_pa;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R3 page hit with offset merge
        '{1'b1, 9'd5, 1'b0, 32'h12345678, 34'h3ABCDE123, 1'b0, 9'd5, 32'h12345ABC, 1'b1, 34'h3ABCDEABC},
        // R5 tag mismatch
        '{1'b0, 9'd0, 1'b0, 32'h0, 34'h0, 1'b0, 9'd6, 32'h12345ABC, 1'b0, 34'h0},
        // R5 page mismatch
        '{1'b0, 9'd0, 1'b0, 32'h0, 34'h0, 1'b0, 9'd5, 32'h12346000, 1'b0, 34'h0},
        // R5 global entry hits under another tag
        '{1'b1, 9'd7, 1'b1, 32'h00400000, 34'h080000000, 1'b0, 9'd1, 32'h00400FFF, 1'b1, 34'h080000FFF},
        // R4 superpage hit, 22 offset bits
        '{1'b1, 9'd3, 1'b0, 32'h40000000, 34'h100C00000, 1'b1, 9'd3, 32'h403ABCDE, 1'b1, 34'h100FABCDE},
        // R4 bit 22 outside superpage
        '{1'b0, 9'd0, 1'b0, 32'h0, 34'h0, 1'b0, 9'd3, 32'h40400000, 1'b0, 34'h0},
        // R4 level 0 compares bit 12
        '{1'b1, 9'd3, 1'b0, 32'h40000000, 34'h100C00000, 1'b0, 9'd3, 32'h40001000, 1'b0, 34'h0},
        // R3 all-ones corner
        '{1'b1, 9'h1FF, 1'b0, 32'hFFFFF000, 34'h3FFFFF777, 1'b0, 9'h1FF, 32'hFFFFFFFF, 1'b1, 34'h3FFFFFFFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_fill(input logic [8:0] a, input logic g, input logic [31:0] va,
                           input logic [33:0] pa, input logic [31:0] pte,
                           input logic [33:0] pta, input logic lvl);
        @(negedge clk);
        fill_asid = a; fill_global = g; fill_vaddr = va; fill_paddr = pa;
        fill_pte = pte; fill_pte_addr = pta; fill_level = lvl; fill_en = 1;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic do_flush(input logic ua, input logic [8:0] a, input logic uv, input logic [31:0] va);
        @(negedge clk);
        flush_use_asid = ua; flush_asid = a; flush_use_addr = uv; flush_vaddr = va; flush_en = 1;
        @(negedge clk);
        flush_en = 0;
    endtask

    task automatic do_upd(input logic [31:0] v);
        @(negedge clk);
        upd_pte = v; upd_en = 1;
        @(negedge clk);
        upd_en = 0;
    endtask

    task automatic look(input logic [8:0] a, input logic [31:0] va);
        lk_asid = a; lk_vaddr = va;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        look(9'd5, 32'h12345678);
        chk(lk_hit == 0, "R1 reset hit", 64'(lk_hit), 0);
        chk(lk_paddr == 0, "R11 reset paddr", 64'(lk_paddr), 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].fill)
                do_fill(VECS[i].f_asid, VECS[i].f_glob, VECS[i].f_va, VECS[i].f_pa,
                        32'hA0000000 | 32'(i), 34'h0, VECS[i].f_lvl);
            look(VECS[i].l_asid, VECS[i].l_va);
            chk(lk_hit == VECS[i].e_hit, "R5 table hit", 64'(lk_hit), 64'(VECS[i].e_hit));
            chk(lk_paddr == VECS[i].e_pa, "R3 table paddr", 64'(lk_paddr), 64'(VECS[i].e_pa));
        end

        // R2 stored fields returned
        do_fill(9'd2, 1'b0, 32'h00003000, 34'h200005000, 32'hDEADBEEF, 34'h100000010, 1'b0);
        look(9'd2, 32'h00003004);
        chk(lk_pte == 32'hDEADBEEF, "R2 pte", 64'(lk_pte), 64'hDEADBEEF);
        chk(lk_pte_addr == 34'h100000010, "R2 pte_addr", 64'(lk_pte_addr), 64'h100000010);
        chk(lk_level == 0 && lk_global == 0, "R2 level/global", 64'({lk_level, lk_global}), 0);

        // R6 update only the entry value
        do_upd(32'h12345678);
        look(9'd2, 32'h00003004);
        chk(lk_pte == 32'h12345678, "R6 new pte", 64'(lk_pte), 64'h12345678);
        chk(lk_paddr == 34'h200005004, "R6 paddr kept", 64'(lk_paddr), 64'h200005004);
        chk(lk_pte_addr == 34'h100000010, "R6 pte_addr kept", 64'(lk_pte_addr), 64'h100000010);

        // R8 tag-qualified flush
        do_flush(1'b1, 9'd3, 1'b0, 32'h0);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 1, "R8 other tag kept", 64'(lk_hit), 1);
        do_flush(1'b1, 9'd2, 1'b0, 32'h0);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 0, "R8 same tag flushed", 64'(lk_hit), 0);
        chk(lk_pte == 0 && lk_pte_addr == 0, "R11 miss fields zero", 64'(lk_pte), 0);

        // R6 update on empty ignored
        do_upd(32'h55555555);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 0, "R6 empty update", 64'(lk_hit), 0);

        // R8 global survives tag flush
        do_fill(9'd2, 1'b1, 32'h00003000, 34'h200005000, 32'h1, 34'h0, 1'b0);
        do_flush(1'b1, 9'd2, 1'b0, 32'h0);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 1 && lk_global == 1, "R8 global kept", 64'(lk_hit), 1);

        // R9 address-qualified flush
        do_flush(1'b0, 9'd0, 1'b1, 32'h00004000);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 1, "R9 other page kept", 64'(lk_hit), 1);
        do_flush(1'b0, 9'd0, 1'b1, 32'h00003FFF);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 0, "R9 same page flushed", 64'(lk_hit), 0);

        // R9 both qualifiers
        do_fill(9'd2, 1'b0, 32'h00003000, 34'h200005000, 32'h2, 34'h0, 1'b0);
        do_flush(1'b1, 9'd2, 1'b1, 32'h00008000);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 1, "R9 both, address differs", 64'(lk_hit), 1);
        do_flush(1'b1, 9'd2, 1'b1, 32'h00003123);
        look(9'd2, 32'h00003004);
        chk(lk_hit == 0, "R9 both match", 64'(lk_hit), 0);

        // R7 unqualified flush and flush on empty
        do_fill(9'd4, 1'b0, 32'h00005000, 34'h000006000, 32'h3, 34'h0, 1'b0);
        do_flush(1'b0, 9'd0, 1'b0, 32'h0);
        look(9'd4, 32'h00005000);
        chk(lk_hit == 0, "R7 flush all", 64'(lk_hit), 0);
        do_flush(1'b0, 9'd0, 1'b0, 32'h0);
        do_fill(9'd4, 1'b0, 32'h00005000, 34'h000006000, 32'h3, 34'h0, 1'b0);
        look(9'd4, 32'h00005010);
        chk(lk_hit == 1 && lk_paddr == 34'h000006010, "R7 fill after empty flush", 64'(lk_paddr), 64'h6010);

        // R10 fill beats flush in the same cycle
        @(negedge clk);
        fill_asid = 9'd9; fill_global = 0; fill_vaddr = 32'h00007000; fill_paddr = 34'h000008000;
        fill_pte = 32'h9; fill_pte_addr = 0; fill_level = 0; fill_en = 1;
        flush_use_asid = 0; flush_use_addr = 0; flush_en = 1;
        @(negedge clk);
        fill_en = 0; flush_en = 0;
        look(9'd9, 32'h00007000);
        chk(lk_hit == 1, "R10 fill over flush", 64'(lk_hit), 1);

        // R10 flush beats update
        @(negedge clk);
        upd_pte = 32'hFFFF0000; upd_en = 1; flush_en = 1;
        @(negedge clk);
        upd_en = 0; flush_en = 0;
        look(9'd9, 32'h00007000);
        chk(lk_hit == 0, "R10 flush over update", 64'(lk_hit), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule